// File: doc/BRIEF.md
# Multi-Level Address Translation Walker

This block turns a 64-bit virtual address into a real address. It walks translation tables held in memory, using one 64-bit entry read at a time. The walk starts at one of four table levels, chosen by the table designation that belongs to the request's address space. It passes down through the remaining region and segment levels and finishes at a page-table entry. The page frame found there, combined with the byte offset, forms the real address. Any address below a fixed low limit is then moved by adding the prefix register.

A request carries the virtual address, an access kind and an address-space mode. The block returns either a real address with read, write and execute permissions, or a fault code with an exception word built from the page-aligned virtual address. When translation is switched off, the virtual address is passed straight through to the prefix stage and no memory is touched. Only one request is in flight at a time. The walker accepts a new request once it has produced a result.

Top module: `dat_walker`

## Requirements
- R1: The designation is chosen by the space mode. Mode 2'b00 uses `cr_primary`, 2'b10 uses `cr_secondary` and 2'b11 uses `cr_home`. Mode 2'b01 is handled exactly like 2'b00.
- R2: Designation bits 3:2 give the starting level: 11 region-first, 10 region-second, 01 region-third, 00 segment. A fault with code 1 (specification) is raised, with no memory read, in each of these cases: a region-second start with any of VA bits 63:53 set; a region-third start with any of bits 63:42 set; a segment start with any of bits 63:31 set.
- R3: Entries are 8 bytes wide. The entry address is the table origin plus eight times the index. Region-first uses VA 63:53, region-second 52:42, region-third 41:31 and segment 30:20, and the page index is VA 19:12. Designation and region entries give an origin from bits 63:12. Segment entries give a page-table origin from bits 63:11.
- R4: Bit 5 set in a region or segment entry gives fault code 2. Bit 10 set in a page entry gives fault code 3.
- R5: A valid region or segment entry whose bits 3:2 differ from the level of the table it was read from gives fault code 1.
- R6: Bit 9 set in a page entry clears the write permission. A write to such a page gives fault code 4.
- R7: On a fault, the exception word is VA with bits 11:0 cleared, ORed with the effective space code in bits 1:0 (primary 0, secondary 2, home 3), ORed with 4 for code 4. A fault returns a real address of 0 and permission 0.
- R8: With `dat_en` low, the real address is the virtual address, the permission is 3'b111, and no memory read is made.
- R9: A real address below 0x2000 has `prefix` added to it. An address of 0x2000 or above is unchanged.
- R10: In secondary mode, a fetch (kind 2) walks through `cr_primary` and gets execute permission only. Reads (kind 0) and writes (kind 1) walk through `cr_secondary` without execute permission.
- R11: At most one read is outstanding. `mem_rd_valid` and `mem_rd_addr` hold until `mem_rd_done`. `rsp_valid` lasts one cycle and is followed by `req_ready`.
- R12: On success, the real address is page-entry bits 63:12 joined with VA bits 11:0, before prefixing. The code is 0 and the exception word is 0. Permission bits are [0] read, [1] write, [2] execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Walker idle |
| req_vaddr | input | 64 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_space | input | 2 | Address-space mode |
| cr_primary | input | 64 | Primary table designation |
| cr_secondary | input | 64 | Secondary table designation |
| cr_home | input | 64 | Home table designation |
| dat_en | input | 1 | Translation enable |
| prefix | input | 64 | Prefix added to low real addresses |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_addr | output | 64 | Entry address |
| mem_rd_done | input | 1 | Read data valid |
| mem_rd_data | input | 64 | Entry value |
| rsp_valid | output | 1 | Result strobe |
| rsp_raddr | output | 64 | Real address |
| rsp_perm | output | 3 | Permissions {exec, write, read} |
| rsp_code | output | 3 | Fault code, 0 for none |
| rsp_exc_word | output | 64 | Exception word |

## Verification
In the final cycle of a walk, the read-only check on the page entry and the prefix addition on the frame address act on the same result. The bench provokes both at once with a page entry whose frame lies at 0x1000 and whose read-only bit is set. A read of that page must return the prefixed address with write permission removed. A write to it must return code 4 with a zero address, so the protection verdict must win over the prefixed address. Secondary-mode fetch and data requests to the same tables check that the choice of space and the permission mask are applied together.

// File: rtl/dat_walker_pkg.sv
package dat_walker_pkg;
   typedef enum logic [2:0] {
      FLT_NONE = 3'd0,
      FLT_SPEC = 3'd1,
      FLT_SEG  = 3'd2,
      FLT_PAGE = 3'd3,
      FLT_PROT = 3'd4
   } flt_e;

   typedef enum logic [1:0] {
      SP_PRI  = 2'b00,
      SP_ALT  = 2'b01,
      SP_SEC  = 2'b10,
      SP_HOME = 2'b11
   } space_e;

   localparam logic [1:0] K_READ  = 2'd0;
   localparam logic [1:0] K_WRITE = 2'd1;
   localparam logic [1:0] K_FETCH = 2'd2;

   localparam int TBL_LEVELS = 4;
   localparam int LVL_W      = 2;
   localparam int TYPE_LSB   = 2;
   localparam int TBL_INV    = 5;
   localparam int PG_INV     = 10;
   localparam int PG_RO      = 9;
   localparam int ENT_SH     = 3;

   localparam logic [2:0] PERM_ALL  = 3'b111;
   localparam logic [2:0] PERM_NOWR = 3'b101;
   localparam logic [2:0] PERM_EXEC = 3'b100;
   localparam logic [2:0] PERM_DATA = 3'b011;
endpackage

// File: rtl/dat_idx_sel.sv
module dat_idx_sel import dat_walker_pkg::*; #(
   parameter int VA_W    = 64,
   parameter int PAGE_SH = 12,
   parameter int PIX_W   = 8,
   parameter int IDX_W   = 11
) (
   input  logic [VA_W-1:0]  va,
   input  logic [LVL_W-1:0] level,
   output logic [IDX_W-1:0] idx,
   output logic [PIX_W-1:0] pix,
   output logic             range_bad
);
   localparam int BASE = PAGE_SH + PIX_W;

   logic [IDX_W-1:0]      idx_arr [TBL_LEVELS];
   logic [TBL_LEVELS-1:0] hi_bad;

   for (genvar l = 0; l < TBL_LEVELS; l++) begin : g_lvl
      localparam int LO = BASE + IDX_W * l;
      localparam int HI = LO + IDX_W;
      assign idx_arr[l] = va[HI-1:LO];
      if (HI < VA_W) begin : g_chk
         assign hi_bad[l] = |va[VA_W-1:HI];
      end else begin : g_top
         assign hi_bad[l] = 1'b0;
      end
   end

   assign idx       = idx_arr[level];
   assign pix       = va[BASE-1:PAGE_SH];
   assign range_bad = hi_bad[level];
endmodule

// File: rtl/dat_entry_eval.sv
module dat_entry_eval import dat_walker_pkg::*; #(
   parameter int VA_W     = 64,
   parameter int PAGE_SH  = 12,
   parameter int PT_ALIGN = 11
) (
   input  logic [VA_W-1:0]  entry,
   input  logic             on_page,
   input  logic [LVL_W-1:0] level,
   output logic [2:0]       code,
   output logic             ro,
   output logic [VA_W-1:0]  next_origin
);
   always_comb begin
      code        = FLT_NONE;
      ro          = 1'b0;
      next_origin = '0;
      if (on_page) begin
         ro = entry[PG_RO];
         if (entry[PG_INV]) code = FLT_PAGE;
      end else if (entry[TBL_INV]) begin
         code = FLT_SEG;
      end else if (entry[TYPE_LSB +: LVL_W] != level) begin
         code = FLT_SPEC;
      end else if (level == '0) begin
         next_origin = {entry[VA_W-1:PT_ALIGN], {PT_ALIGN{1'b0}}};
      end else begin
         next_origin = {entry[VA_W-1:PAGE_SH], {PAGE_SH{1'b0}}};
      end
   end
endmodule

// File: rtl/dat_prefix.sv
module dat_prefix #(
   parameter int              AW        = 64,
   parameter logic [AW-1:0]   LOW_LIMIT = 'h2000
) (
   input  logic [AW-1:0] addr_in,
   input  logic [AW-1:0] prefix,
   output logic [AW-1:0] addr_out
);
   assign addr_out = (addr_in < LOW_LIMIT) ? addr_in + prefix : addr_in;
endmodule

// File: rtl/dat_walker.sv
module dat_walker import dat_walker_pkg::*; #(
   parameter int          VA_W      = 64,
   parameter int          PAGE_SH   = 12,
   parameter int          PIX_W     = 8,
   parameter int          IDX_W     = 11,
   parameter int          PT_ALIGN  = 11,
   parameter logic [63:0] LOW_LIMIT = 64'h2000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [VA_W-1:0] req_vaddr,
   input  logic [1:0]      req_kind,
   input  logic [1:0]      req_space,
   input  logic [VA_W-1:0] cr_primary,
   input  logic [VA_W-1:0] cr_secondary,
   input  logic [VA_W-1:0] cr_home,
   input  logic            dat_en,
   input  logic [VA_W-1:0] prefix,
   output logic            mem_rd_valid,
   output logic [VA_W-1:0] mem_rd_addr,
   input  logic            mem_rd_done,
   input  logic [VA_W-1:0] mem_rd_data,
   output logic            rsp_valid,
   output logic [VA_W-1:0] rsp_raddr,
   output logic [2:0]      rsp_perm,
   output logic [2:0]      rsp_code,
   output logic [VA_W-1:0] rsp_exc_word
);
   localparam int SPAN = PAGE_SH + PIX_W + TBL_LEVELS * IDX_W;

   if (SPAN != VA_W) begin : g_bad_span
      $error("dat_walker: index fields do not cover the virtual address");
   end
   if (PT_ALIGN < PIX_W + ENT_SH || PAGE_SH < 3) begin : g_bad_align
      $error("dat_walker: table alignment too small for its index");
   end

   typedef enum logic [1:0] {ST_IDLE, ST_START, ST_FETCH, ST_RESP} st_e;

   st_e             state;
   logic [VA_W-1:0] va_q, base_q, res_raddr, res_exc;
   logic            write_q, on_page_q;
   logic [1:0]      space_q;
   logic [2:0]      pmask_q, res_perm, res_code;
   logic [LVL_W-1:0] level_q;

   // effective space and permission mask for a new request
   logic [1:0] eff_space;
   logic [2:0] eff_mask;
   always_comb begin
      eff_mask = PERM_ALL;
      unique case (req_space)
         SP_SEC: begin
            if (req_kind == K_FETCH) begin
               eff_space = SP_PRI;
               eff_mask  = PERM_EXEC;
            end else begin
               eff_space = SP_SEC;
               eff_mask  = PERM_DATA;
            end
         end
         SP_HOME: eff_space = SP_HOME;
         default: eff_space = SP_PRI;
      endcase
   end

   logic [VA_W-1:0] desig;
   always_comb begin
      unique case (space_q)
         SP_SEC:  desig = cr_secondary;
         SP_HOME: desig = cr_home;
         default: desig = cr_primary;
      endcase
   end

   logic [LVL_W-1:0] lvl_cur;
   logic [IDX_W-1:0] idx;
   logic [PIX_W-1:0] pix;
   logic             range_bad;
   assign lvl_cur = (state == ST_START) ? desig[TYPE_LSB +: LVL_W] : level_q;

   dat_idx_sel #(.VA_W(VA_W), .PAGE_SH(PAGE_SH), .PIX_W(PIX_W), .IDX_W(IDX_W)) i_idx (
      .va(va_q), .level(lvl_cur), .idx(idx), .pix(pix), .range_bad(range_bad));

   logic [2:0]      ev_code;
   logic            ev_ro;
   logic [VA_W-1:0] ev_next;
   dat_entry_eval #(.VA_W(VA_W), .PAGE_SH(PAGE_SH), .PT_ALIGN(PT_ALIGN)) i_eval (
      .entry(mem_rd_data), .on_page(on_page_q), .level(level_q),
      .code(ev_code), .ro(ev_ro), .next_origin(ev_next));

   // result of the current cycle, if any
   logic            fin;
   logic [2:0]      fin_code, fin_perm;
   logic [VA_W-1:0] cand, cand_pref;
   always_comb begin
      fin      = 1'b0;
      fin_code = FLT_NONE;
      fin_perm = '0;
      cand     = va_q;
      if (state == ST_START) begin
         if (!dat_en) begin
            fin      = 1'b1;
            fin_perm = PERM_ALL;
         end else if (range_bad) begin
            fin      = 1'b1;
            fin_code = FLT_SPEC;
         end
      end else if (state == ST_FETCH && mem_rd_done) begin
         if (ev_code != FLT_NONE) begin
            fin      = 1'b1;
            fin_code = ev_code;
         end else if (on_page_q) begin
            fin  = 1'b1;
            cand = {mem_rd_data[VA_W-1:PAGE_SH], va_q[PAGE_SH-1:0]};
            if (write_q && ev_ro) fin_code = FLT_PROT;
            else fin_perm = pmask_q & (ev_ro ? PERM_NOWR : PERM_ALL);
         end
      end
   end

   dat_prefix #(.AW(VA_W), .LOW_LIMIT(VA_W'(LOW_LIMIT))) i_pref (
      .addr_in(cand), .prefix(prefix), .addr_out(cand_pref));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         va_q      <= '0;
         write_q   <= 1'b0;
         space_q   <= SP_PRI;
         pmask_q   <= PERM_ALL;
         base_q    <= '0;
         level_q   <= '0;
         on_page_q <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (req_valid) begin
               va_q    <= req_vaddr;
               write_q <= (req_kind == K_WRITE);
               space_q <= eff_space;
               pmask_q <= eff_mask;
               state   <= ST_START;
            end
            ST_START: begin
               if (fin) begin
                  state <= ST_RESP;
               end else begin
                  base_q    <= {desig[VA_W-1:PAGE_SH], {PAGE_SH{1'b0}}};
                  level_q   <= desig[TYPE_LSB +: LVL_W];
                  on_page_q <= 1'b0;
                  state     <= ST_FETCH;
               end
            end
            ST_FETCH: if (mem_rd_done) begin
               if (fin) begin
                  state <= ST_RESP;
               end else begin
                  base_q <= ev_next;
                  if (level_q == '0) on_page_q <= 1'b1;
                  else level_q <= level_q - 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_code  <= FLT_NONE;
         res_perm  <= '0;
         res_raddr <= '0;
         res_exc   <= '0;
      end else if (fin) begin
         res_code  <= fin_code;
         res_perm  <= fin_perm;
         res_raddr <= (fin_code == FLT_NONE) ? cand_pref : '0;
         res_exc   <= (fin_code == FLT_NONE) ? '0 :
                      {va_q[VA_W-1:PAGE_SH], {(PAGE_SH-3){1'b0}},
                       (fin_code == FLT_PROT), space_q};
      end
   end

   assign req_ready    = (state == ST_IDLE);
   assign mem_rd_valid = (state == ST_FETCH);
   assign mem_rd_addr  = base_q + (on_page_q ? (VA_W'(pix) << ENT_SH)
                                             : (VA_W'(idx) << ENT_SH));
   assign rsp_valid    = (state == ST_RESP);
   assign rsp_raddr    = res_raddr;
   assign rsp_perm     = res_perm;
   assign rsp_code     = res_code;
   assign rsp_exc_word = res_exc;
endmodule

// File: rtl/dat_walker_chk.sv
module dat_walker_chk #(
   parameter int VA_W = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_ready,
   input logic            mem_rd_valid,
   input logic [VA_W-1:0] mem_rd_addr,
   input logic            mem_rd_done,
   input logic            rsp_valid,
   input logic [2:0]      rsp_code,
   input logic [2:0]      rsp_perm,
   input logic [VA_W-1:0] rsp_raddr,
   input logic [VA_W-1:0] rsp_exc_word
);
   a_r11_read_held: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid && !mem_rd_done |=> mem_rd_valid && $stable(mem_rd_addr));

   a_r11_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid && req_ready);

   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_rd_valid && !rsp_valid);

   a_r7_prot_word: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_code == 3'd4 |-> rsp_exc_word[2] && rsp_perm == 3'b000 && rsp_raddr == '0);

   a_r7_walk_fault_word: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_code inside {3'd1, 3'd2, 3'd3} |->
         !rsp_exc_word[2] && rsp_exc_word[11:3] == '0 && rsp_perm == 3'b000);

   a_r12_clean_word: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_code == 3'd0 |-> rsp_exc_word == '0);
endmodule

bind dat_walker dat_walker_chk #(.VA_W(VA_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
   .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr), .mem_rd_done(mem_rd_done),
   .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_perm(rsp_perm),
   .rsp_raddr(rsp_raddr), .rsp_exc_word(rsp_exc_word));

// File: tb/test_dat_walker.sv
module test_dat_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [63:0] req_vaddr = '0;
   logic [1:0]  req_kind = '0;
   logic [1:0]  req_space = '0;
   logic [63:0] cr_primary = '0, cr_secondary = '0, cr_home = '0;
   logic        dat_en = 1'b0;
   logic [63:0] prefix = 64'h40000;
   logic        mem_rd_valid;
   logic [63:0] mem_rd_addr;
   logic        mem_rd_done = 1'b0;
   logic [63:0] mem_rd_data = '0;
   logic        rsp_valid;
   logic [63:0] rsp_raddr;
   logic [2:0]  rsp_perm;
   logic [2:0]  rsp_code;
   logic [63:0] rsp_exc_word;

   always #10 clk = ~clk;

   dat_walker i_dat_walker (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_kind(req_kind), .req_space(req_space),
      .cr_primary(cr_primary), .cr_secondary(cr_secondary), .cr_home(cr_home),
      .dat_en(dat_en), .prefix(prefix),
      .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
      .mem_rd_done(mem_rd_done), .mem_rd_data(mem_rd_data),
      .rsp_valid(rsp_valid), .rsp_raddr(rsp_raddr), .rsp_perm(rsp_perm),
      .rsp_code(rsp_code), .rsp_exc_word(rsp_exc_word));

   logic [63:0] mem [logic [63:0]];

   function automatic logic [63:0] peek(input logic [63:0] a);
      return mem.exists(a) ? mem[a] : 64'd0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) mem_rd_done <= 1'b0;
      else if (mem_rd_valid && !mem_rd_done) begin
         mem_rd_done <= 1'b1;
         mem_rd_data <= peek(mem_rd_addr);
      end else mem_rd_done <= 1'b0;
   end

   typedef struct {
      logic [2:0]  code;
      logic [63:0] raddr;
      logic [2:0]  perm;
      logic [63:0] exc;
      int          reads;
      int          snap;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   errors = 0;
   int   rd_total = 0;
   bit   finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && mem_rd_valid && mem_rd_done) rd_total++;
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R11 unexpected response", 64'd1, 64'd0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(rsp_code == e.code, {e.tag, " code"}, 64'(rsp_code), 64'(e.code));
            chk(rsp_raddr == e.raddr, {e.tag, " raddr"}, rsp_raddr, e.raddr);
            chk(rsp_perm == e.perm, {e.tag, " perm"}, 64'(rsp_perm), 64'(e.perm));
            chk(rsp_exc_word == e.exc, {e.tag, " exc word"}, rsp_exc_word, e.exc);
            chk(rd_total - e.snap == e.reads, {e.tag, " R11 read count"},
                64'(rd_total - e.snap), 64'(e.reads));
         end
      end
   end

   // driver: queues the expectation, presents the request, waits for the result
   task automatic xlate(input logic [63:0] va, input logic [1:0] kind, input logic [1:0] space,
                        input logic [2:0] code, input logic [63:0] raddr, input logic [2:0] perm,
                        input logic [63:0] exc, input int reads, input string tag);
      exp_t e;
      while (!req_ready) @(negedge clk);
      e.code = code; e.raddr = raddr; e.perm = perm; e.exc = exc;
      e.reads = reads; e.snap = rd_total; e.tag = tag;
      exp_q.push_back(e);
      req_vaddr = va; req_kind = kind; req_space = space; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      while (exp_q.size() != 0) @(negedge clk);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL R11 watchdog: actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   localparam logic [63:0] VA_A = 64'h123456;
   localparam logic [63:0] VA_B = 64'h124abc;
   localparam logic [63:0] VA_C = 64'h125010;
   localparam logic [63:0] UP3  = (64'd2 << 42) | (64'd3 << 31);

   initial begin
      // segment table at 0x10000 (R3, R4, R5)
      mem[64'h10008] = 64'h20000;
      mem[64'h10010] = 64'h20;
      mem[64'h10018] = 64'h21004;
      // page table at 0x20000 (R6, R9, R4)
      mem[64'h20118] = 64'h55000;
      mem[64'h20120] = 64'h66200;
      mem[64'h20128] = 64'h1200;
      mem[64'h20130] = 64'h400;
      // region tables
      mem[64'h30008] = 64'h3400C;
      mem[64'h30010] = 64'h20;
      mem[64'h34010] = 64'h38008;
      mem[64'h38018] = 64'h10004;
      cr_primary   = 64'h10000;
      cr_secondary = 64'h34008;
      cr_home      = 64'h3000C;

      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1, "R11 reset ready", 64'(req_ready), 64'd1);
      chk(rsp_valid == 1'b0, "R11 reset rsp_valid", 64'(rsp_valid), 64'd0);
      chk(mem_rd_valid == 1'b0, "R11 reset read", 64'(mem_rd_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // translation off
      xlate(64'h1234, 2'd0, 2'b00, 3'd0, 64'h41234, 3'b111, 64'd0, 0, "R8 R9 dat off low");
      xlate(64'h2000, 2'd1, 2'b00, 3'd0, 64'h2000, 3'b111, 64'd0, 0, "R9 at limit");
      xlate(64'h1fff, 2'd2, 2'b10, 3'd0, 64'h41fff, 3'b111, 64'd0, 0, "R9 R8 below limit");
      dat_en = 1'b1;

      // segment-start walks through primary
      xlate(VA_A, 2'd0, 2'b00, 3'd0, 64'h55456, 3'b111, 64'd0, 2, "R3 R12 primary read");
      xlate(VA_A, 2'd1, 2'b00, 3'd0, 64'h55456, 3'b111, 64'd0, 2, "R12 primary write");
      xlate(VA_A, 2'd0, 2'b01, 3'd0, 64'h55456, 3'b111, 64'd0, 2, "R1 mode 01 as primary");
      xlate(VA_B, 2'd0, 2'b00, 3'd0, 64'h66abc, 3'b101, 64'd0, 2, "R6 read-only read");
      xlate(VA_B, 2'd1, 2'b00, 3'd4, 64'd0, 3'b000, 64'h124004, 2, "R6 R7 protection");
      // protection and prefix on one result
      xlate(VA_C, 2'd0, 2'b00, 3'd0, 64'h41010, 3'b101, 64'd0, 2, "R9 R6 prefixed frame");
      xlate(VA_C, 2'd1, 2'b00, 3'd4, 64'd0, 3'b000, 64'h125004, 2, "R6 R9 protection wins");
      xlate(64'h126000, 2'd0, 2'b00, 3'd3, 64'd0, 3'b000, 64'h126000, 2, "R4 page invalid");
      xlate(64'h200000, 2'd0, 2'b00, 3'd2, 64'd0, 3'b000, 64'h200000, 1, "R4 segment invalid");
      xlate(64'h300000, 2'd0, 2'b00, 3'd1, 64'd0, 3'b000, 64'h300000, 1, "R5 entry type mismatch");
      xlate(64'h8000_0abc, 2'd0, 2'b00, 3'd1, 64'd0, 3'b000, 64'h8000_0000, 0, "R2 segment range");

      // region-first start in home space
      xlate((64'd1 << 53) | UP3 | VA_A, 2'd0, 2'b11, 3'd0, 64'h55456, 3'b111, 64'd0, 5,
            "R1 R2 R3 home five levels");
      xlate(64'd2 << 53, 2'd0, 2'b11, 3'd2, 64'd0, 3'b000, (64'd2 << 53) | 64'd3, 1,
            "R4 R7 region invalid");

      // secondary mode, region-second start
      xlate(UP3 | VA_A, 2'd0, 2'b10, 3'd0, 64'h55456, 3'b011, 64'd0, 4, "R10 secondary data");
      xlate(VA_A, 2'd2, 2'b10, 3'd0, 64'h55456, 3'b100, 64'd0, 2, "R10 secondary fetch");
      xlate(UP3 | VA_B, 2'd1, 2'b10, 3'd4, 64'd0, 3'b000, ((UP3 | VA_B) & ~64'hfff) | 64'd6, 4,
            "R7 R10 secondary protection");
      xlate((64'd1 << 53) | 64'h777, 2'd0, 2'b10, 3'd1, 64'd0, 3'b000, (64'd1 << 53) | 64'd2, 0,
            "R2 region-second range");
      xlate(VA_A, 2'd2, 2'b00, 3'd0, 64'h55456, 3'b111, 64'd0, 2, "R10 primary fetch full");

      // region-third start in home space
      cr_home = 64'h38004;
      xlate((64'd3 << 31) | VA_A, 2'd0, 2'b11, 3'd0, 64'h55456, 3'b111, 64'd0, 3, "R2 R1 third start");
      xlate(64'd1 << 42, 2'd0, 2'b11, 3'd1, 64'd0, 3'b000, (64'd1 << 42) | 64'd3, 0,
            "R2 region-third range");

      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1, "R11 idle after run", 64'(req_ready), 64'd1);
      finished = 1'b1;
      summary();
      $finish;
   end
endmodule